// File: doc/BRIEF.md
# Conditional Data-Processing Execute Unit

This block carries out one 32-bit data-processing instruction word per clock cycle. The surrounding datapath supplies three things: the value of the first source register, a second operand that has already been shifted or rotated, and the carry produced by that shifter. The block holds the only state of the unit, a four-bit negative/zero/carry/overflow flag register. It tests the instruction's condition field against these flags. When the condition holds, it computes one of sixteen operations selected by the command field.

The result, the destination register index and a write strobe are combinational outputs in the same cycle. When the instruction asks for it, the flags are rewritten at the next rising clock edge. The register file, the operand shifter and instruction fetch lie outside the block. Only words whose class field (bits 27:26) is 00 are acted on.

Top module: `dp_exec_unit`

## Requirements
- R1: A synchronous active-low reset clears the flag output `flags_o` to 0000. The flag bits are packed as N=bit 3, Z=bit 2, C=bit 1, V=bit 0.
- R2: The condition field in bits 31:28 passes under these rules: 0000 when Z=1, 0001 when Z=0, 0010 when C=1, 0011 when C=0, 0100 when N=1, 0101 when N=0, 0110 when V=1, 0111 when V=0.
- R3: The compound codes pass under these rules: 1000 when C=1 and Z=0, 1001 when C=0 or Z=1, 1010 when N==V, 1011 when N!=V, 1100 when Z=0 and N==V, 1101 when Z=1 or N!=V. Code 1110 always passes and code 1111 never passes.
- R4: Command field bits 24:21 select the logical operations: 0000 gives Rn AND Op2, 0001 gives Rn XOR Op2, 1100 gives Rn OR Op2, 1101 gives Op2, 1110 gives Rn AND NOT Op2, and 1111 gives NOT Op2.
- R5: Command 0100 gives Rn+Op2, command 0010 gives Rn-Op2, and command 0011 gives Op2-Rn.
- R6: The carry-using commands read the registered C flag: 0101 gives Rn+Op2+C, 0110 gives Rn-Op2+C-1, and 0111 gives Op2-Rn+C-1.
- R7: The test commands never raise the write strobe. These are 1000 (Rn AND Op2), 1001 (Rn XOR Op2), 1010 (Rn-Op2) and 1011 (Rn+Op2). With S set they still update the flags.
- R8: When bit 20 (S) is 0, the flags are unchanged after the edge.
- R9: For arithmetic commands with S set, C becomes the adder carry-out and V becomes the signed overflow. For subtraction, C=1 means no borrow.
- R10: For logical commands with S set, C becomes the shifter carry input and V is kept. For every S update, N becomes result bit 31 and Z becomes 1 exactly when the result is zero.
- R11: A failing condition gives no write strobe and no flag change.
- R12: A word whose bits 27:26 are not 00 gives no write strobe and no flag change.
- R13: `rd_o` carries bits 15:12. `res_o` and `rd_we_o` reflect the current inputs in the same cycle, and flag changes appear after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_i | input | 32 | Instruction word |
| rn_val_i | input | DATA_W | First source operand value |
| op2_val_i | input | DATA_W | Prepared second operand value |
| shift_carry_i | input | 1 | Carry out of the operand shifter |
| res_o | output | DATA_W | Operation result |
| rd_o | output | 4 | Destination register index |
| rd_we_o | output | 1 | Destination write strobe |
| flags_o | output | 4 | Registered flags {N,Z,C,V} |

## Verification
The assertions assume that reset is held low from time zero until at least one rising edge has passed. They also assume that every input is a known value that stays stable across each rising edge, since the flag update samples the instruction word at that edge. The bench holds reset low for several cycles before the first instruction. It changes every input only on the falling clock edge, and it builds each instruction word through one helper so that every field carries a defined value. Flag states for the condition sweep are reached only through instructions. Because N and Z cannot both be 1 through a move, that combination is never produced.

// File: rtl/dpu_pkg.sv
// Package dpu_pkg
// Shared encodings for the data-processing execute unit. It assumes a
// 32-bit instruction word with the field positions given below.
package dpu_pkg;

    localparam int INSTR_W = 32;

    typedef enum logic [3:0] {
        CMD_AND = 4'h0, CMD_EOR = 4'h1, CMD_SUB = 4'h2, CMD_RSB = 4'h3,
        CMD_ADD = 4'h4, CMD_ADC = 4'h5, CMD_SBC = 4'h6, CMD_RSC = 4'h7,
        CMD_TST = 4'h8, CMD_TEQ = 4'h9, CMD_CMP = 4'hA, CMD_CMN = 4'hB,
        CMD_ORR = 4'hC, CMD_MOV = 4'hD, CMD_BIC = 4'hE, CMD_MVN = 4'hF
    } cmd_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

endpackage

// File: rtl/dpu_cond_gate.sv
// Module dpu_cond_gate
// Decides whether an instruction may execute under the current flags.
// Codes are grouped in pairs: bits 3:1 pick a base test and bit 0
// inverts it. The last pair is the exception: always / never.
module dpu_cond_gate
    import dpu_pkg::*;
(
    input  logic [3:0] cond_i,
    input  nzcv_t      flags_i,
    output logic       pass_o
);

    logic base;

    // Evaluate the base test for the pair selected by bits 3:1.
    always_comb begin
        case (cond_i[3:1])
            3'd0:    base = flags_i.z;
            3'd1:    base = flags_i.c;
            3'd2:    base = flags_i.n;
            3'd3:    base = flags_i.v;
            3'd4:    base = flags_i.c & ~flags_i.z;
            3'd5:    base = ~(flags_i.n ^ flags_i.v);
            3'd6:    base = ~flags_i.z & ~(flags_i.n ^ flags_i.v);
            default: base = 1'b1;
        endcase
    end

    // Apply the inversion bit; in the last pair the odd code means never.
    always_comb begin
        pass_o = base ^ cond_i[0];
    end

endmodule

// File: rtl/dpu_alu.sv
// Module dpu_alu
// One shared adder serves all eight arithmetic commands through operand
// swap and inversion. The logical commands take the shifter carry.
// It assumes the operand is already shifted.
module dpu_alu
    import dpu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  cmd_e              cmd_i,
    input  logic [DATA_W-1:0] rn_i,
    input  logic [DATA_W-1:0] op2_i,
    input  nzcv_t             flags_i,
    input  logic              sh_carry_i,
    output logic [DATA_W-1:0] res_o,
    output nzcv_t             next_o
);

    localparam int SUM_W = DATA_W + 1;

    logic [DATA_W-1:0] add_a, add_b, logic_res;
    logic              add_ci, is_arith;
    logic [SUM_W-1:0]  sum;

    // Choose adder operands and carry-in for each arithmetic command.
    always_comb begin
        add_a    = rn_i;
        add_b    = op2_i;
        add_ci   = 1'b0;
        is_arith = 1'b1;
        case (cmd_i)
            CMD_SUB, CMD_CMP: begin add_b = ~op2_i; add_ci = 1'b1; end
            CMD_RSB:          begin add_a = op2_i; add_b = ~rn_i; add_ci = 1'b1; end
            CMD_ADD, CMD_CMN: add_ci = 1'b0;
            CMD_ADC:          add_ci = flags_i.c;
            CMD_SBC:          begin add_b = ~op2_i; add_ci = flags_i.c; end
            CMD_RSC:          begin add_a = op2_i; add_b = ~rn_i; add_ci = flags_i.c; end
            default:          is_arith = 1'b0;
        endcase
    end

    // Single carry-propagate adder shared by all arithmetic commands.
    always_comb begin
        sum = {1'b0, add_a} + {1'b0, add_b} + {{DATA_W{1'b0}}, add_ci};
    end

    // Bitwise and move results.
    always_comb begin
        case (cmd_i)
            CMD_AND, CMD_TST: logic_res = rn_i & op2_i;
            CMD_EOR, CMD_TEQ: logic_res = rn_i ^ op2_i;
            CMD_ORR:          logic_res = rn_i | op2_i;
            CMD_MOV:          logic_res = op2_i;
            CMD_BIC:          logic_res = rn_i & ~op2_i;
            default:          logic_res = ~op2_i;
        endcase
    end

    // Merge the result and form candidate flags.
    always_comb begin
        res_o  = is_arith ? sum[DATA_W-1:0] : logic_res;
        next_o.n = res_o[DATA_W-1];
        next_o.z = (res_o == '0);
        next_o.c = is_arith ? sum[DATA_W] : sh_carry_i;
        next_o.v = is_arith ? ((add_a[DATA_W-1] == add_b[DATA_W-1]) &&
                               (sum[DATA_W-1] != add_a[DATA_W-1]))
                            : flags_i.v;
    end

endmodule

// File: rtl/dpu_flag_reg.sv
// Module dpu_flag_reg
// Holds the four condition flags. It assumes a synchronous active-low
// reset and an update strobe that is valid at the rising edge.
module dpu_flag_reg
    import dpu_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  upd_i,
    input  nzcv_t next_i,
    output nzcv_t flags_o
);

    // Clear on reset, otherwise load when an update is requested.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_o <= '0;
        else if (upd_i)
            flags_o <= next_i;
    end

endmodule

// File: rtl/dp_exec_unit.sv
// Module dp_exec_unit
// Executes one data-processing word per cycle. Result and write strobe
// are combinational; flags update at the next edge when S is set. It
// assumes operand 2 and the shifter carry come ready from outside.
module dp_exec_unit
    import dpu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       instr_i,
    input  logic [DATA_W-1:0] rn_val_i,
    input  logic [DATA_W-1:0] op2_val_i,
    input  logic              shift_carry_i,
    output logic [DATA_W-1:0] res_o,
    output logic [3:0]        rd_o,
    output logic              rd_we_o,
    output logic [3:0]        flags_o
);

    logic [3:0] cond_f;
    logic [1:0] class_f;
    cmd_e       cmd_f;
    logic       s_f, pass, is_dp, is_test, upd;
    nzcv_t      flags_q, flags_nxt;

    // Split the instruction word into fields.
    always_comb begin
        cond_f  = instr_i[31:28];
        class_f = instr_i[27:26];
        cmd_f   = cmd_e'(instr_i[24:21]);
        s_f     = instr_i[20];
        rd_o    = instr_i[15:12];
    end

    dpu_cond_gate i_cond (
        .cond_i  (cond_f),
        .flags_i (flags_q),
        .pass_o  (pass)
    );

    dpu_alu #(.DATA_W(DATA_W)) i_alu (
        .cmd_i      (cmd_f),
        .rn_i       (rn_val_i),
        .op2_i      (op2_val_i),
        .flags_i    (flags_q),
        .sh_carry_i (shift_carry_i),
        .res_o      (res_o),
        .next_o     (flags_nxt)
    );

    // Gate the write and flag update on class, condition and command.
    always_comb begin
        is_dp   = (class_f == 2'b00);
        is_test = (cmd_f[3:2] == 2'b10);
        rd_we_o = is_dp && pass && !is_test;
        upd     = is_dp && pass && s_f;
    end

    dpu_flag_reg i_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_i   (upd),
        .next_i  (flags_nxt),
        .flags_o (flags_q)
    );

    // Expose the packed flags.
    always_comb flags_o = flags_q;

endmodule

// File: rtl/dp_exec_checker.sv
// Module dp_exec_checker
// Temporal checks on the ports of dp_exec_unit, attached by bind.
module dp_exec_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [31:0]       instr_i,
    input logic [DATA_W-1:0] res_o,
    input logic [3:0]        rd_o,
    input logic              rd_we_o,
    input logic [3:0]        flags_o
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> flags_o == 4'b0000);

    assert_test_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[24:23] == 2'b10) |-> !rd_we_o);

    assert_s_clear_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_i[20] |=> $stable(flags_o));

    assert_nz_track_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_we_o && instr_i[20]) |=>
        (flags_o[3] == $past(res_o[DATA_W-1]) && flags_o[2] == ($past(res_o) == '0)));

    assert_never_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[31:28] == 4'hF) |-> !rd_we_o);

    assert_never_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[31:28] == 4'hF) |=> $stable(flags_o));

    assert_class_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[27:26] != 2'b00) |=> $stable(flags_o));

    assert_dest_field_R13: assert property (@(posedge clk) disable iff (!rst_n)
        rd_o == instr_i[15:12]);

endmodule

bind dp_exec_unit dp_exec_checker #(.DATA_W(DATA_W)) i_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .instr_i (instr_i),
    .res_o   (res_o),
    .rd_o    (rd_o),
    .rd_we_o (rd_we_o),
    .flags_o (flags_o)
);

// File: tb/test_dp_exec_unit.sv
module test_dp_exec_unit;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] NOP = 32'hF000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = NOP;
    logic [31:0] rn = '0, op2 = '0;
    logic        sc = 1'b0;
    logic [31:0] res;
    logic [3:0]  rd, flags;
    logic        we;
    int          total = 0, bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dp_exec_unit #(.DATA_W(32)) i_dp_exec_unit (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .rn_val_i(rn),
        .op2_val_i(op2), .shift_carry_i(sc), .res_o(res), .rd_o(rd),
        .rd_we_o(we), .flags_o(flags)
    );

    function automatic logic [31:0] mk(input logic [3:0] c, input logic [3:0] cmd,
                                       input logic s, input logic [3:0] rdi);
        return {c, 2'b00, 1'b0, cmd, s, 4'h1, rdi, 12'h000};
    endfunction

    function automatic logic ref_pass(input logic [3:0] c, input logic [3:0] f);
        logic n, z, cy, v;
        {n, z, cy, v} = f;
        case (c)
            4'h0: return z;          4'h1: return !z;
            4'h2: return cy;         4'h3: return !cy;
            4'h4: return n;          4'h5: return !n;
            4'h6: return v;          4'h7: return !v;
            4'h8: return cy && !z;   4'h9: return !cy || z;
            4'hA: return n == v;     4'hB: return n != v;
            4'hC: return !z && (n == v);
            4'hD: return z || (n != v);
            4'hE: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    // Drive one instruction for one cycle; outputs settle 1 time unit later.
    task automatic exec(input logic [31:0] w, input logic [31:0] a,
                        input logic [31:0] b, input logic c);
        @(negedge clk);
        instr = w; rn = a; op2 = b; sc = c;
        #1;
    endtask

    // Let the previous instruction pass its edge, then idle.
    task automatic settle();
        exec(NOP, 0, 0, 0);
    endtask

    // Reach a flag state through instructions only (N and Z not both 1).
    task automatic set_flags(input logic [3:0] f);
        exec(mk(4'hE, 4'h4, 1'b1, 4'h0), f[0] ? 32'h7FFF_FFFF : 32'h0, f[0] ? 32'h1 : 32'h0, 1'b0);
        exec(mk(4'hE, 4'hD, 1'b1, 4'h0), 32'h0, f[3] ? 32'h8000_0000 : (f[2] ? 32'h0 : 32'h1), f[1]);
        settle();
    endtask

    task automatic t_reset();
        chk("R1 flags after reset", {28'h0, flags}, 32'h0);
        set_flags(4'b1011);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); #1;
        chk("R1 flags after mid-run reset", {28'h0, flags}, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_cond_sweep();
        for (int f = 0; f < 16; f++) begin
            if (f[3] && f[2]) continue;
            set_flags(f[3:0]);
            for (int c = 0; c < 16; c++) begin
                exec(mk(c[3:0], 4'h4, 1'b0, 4'h2), 1, 1, 0);
                chk($sformatf("%s cond=%h flags=%h", c < 8 ? "R2" : "R3", c, f),
                    {31'h0, we}, {31'h0, ref_pass(c[3:0], f[3:0])});
            end
            settle();
            chk("R8 S clear keeps flags", {28'h0, flags}, {28'h0, f[3:0]});
        end
    endtask

    task automatic t_logical();
        logic [31:0] a = 32'hF0F0_1234, b = 32'h0FF0_00FF;
        exec(mk(4'hE, 4'h0, 1'b0, 4'h3), a, b, 0); chk("R4 AND", res, 32'h00F0_0034);
        chk("R4 AND write", {31'h0, we}, 1);
        exec(mk(4'hE, 4'h1, 1'b0, 4'h3), a, b, 0); chk("R4 EOR", res, 32'hFF00_12CB);
        exec(mk(4'hE, 4'hC, 1'b0, 4'h3), a, b, 0); chk("R4 ORR", res, 32'hFFF0_12FF);
        exec(mk(4'hE, 4'hD, 1'b0, 4'h3), a, b, 0); chk("R4 MOV", res, 32'h0FF0_00FF);
        exec(mk(4'hE, 4'hE, 1'b0, 4'h3), a, b, 0); chk("R4 BIC", res, 32'hF000_1200);
        exec(mk(4'hE, 4'hF, 1'b0, 4'h3), a, b, 0); chk("R4 MVN", res, 32'hF00F_FF00);
        settle();
    endtask

    task automatic t_arith();
        exec(mk(4'hE, 4'h4, 1'b0, 4'h5), 5, 6, 0);  chk("R5 ADD", res, 11);
        exec(mk(4'hE, 4'h2, 1'b0, 4'h5), 10, 3, 0); chk("R5 SUB", res, 7);
        exec(mk(4'hE, 4'h3, 1'b0, 4'h5), 3, 10, 0); chk("R5 RSB", res, 7);
        settle();
    endtask

    task automatic t_carry_ops();
        set_flags(4'b0010);
        exec(mk(4'hE, 4'h5, 1'b0, 4'h1), 5, 6, 0);  chk("R6 ADC C=1", res, 12);
        exec(mk(4'hE, 4'h6, 1'b0, 4'h1), 10, 3, 0); chk("R6 SBC C=1", res, 7);
        set_flags(4'b0000);
        exec(mk(4'hE, 4'h5, 1'b0, 4'h1), 5, 6, 0);  chk("R6 ADC C=0", res, 11);
        exec(mk(4'hE, 4'h6, 1'b0, 4'h1), 10, 3, 0); chk("R6 SBC C=0", res, 6);
        exec(mk(4'hE, 4'h7, 1'b0, 4'h1), 3, 10, 0); chk("R6 RSC C=0", res, 6);
        settle();
    endtask

    task automatic t_tests();
        set_flags(4'b0001);
        exec(mk(4'hE, 4'h8, 1'b1, 4'h4), 32'hF0, 32'h0F, 1);
        chk("R7 TST no write", {31'h0, we}, 0);
        settle(); chk("R10 TST flags", {28'h0, flags}, 32'b0111);
        set_flags(4'b0001);
        exec(mk(4'hE, 4'h9, 1'b1, 4'h4), 32'h8000_0001, 32'h8000_0001, 0);
        chk("R7 TEQ no write", {31'h0, we}, 0);
        settle(); chk("R10 TEQ flags", {28'h0, flags}, 32'b0101);
        exec(mk(4'hE, 4'hA, 1'b1, 4'h4), 5, 5, 0);
        chk("R7 CMP no write", {31'h0, we}, 0);
        settle(); chk("R7 CMP flags", {28'h0, flags}, 32'b0110);
        exec(mk(4'hE, 4'hB, 1'b1, 4'h4), 32'hFFFF_FFFF, 1, 0);
        chk("R7 CMN no write", {31'h0, we}, 0);
        settle(); chk("R7 CMN flags", {28'h0, flags}, 32'b0110);
    endtask

    task automatic t_arith_flags();
        exec(mk(4'hE, 4'h2, 1'b1, 4'h6), 3, 5, 0);
        chk("R9 SUBS result", res, 32'hFFFF_FFFE);
        settle(); chk("R9 SUBS borrow flags", {28'h0, flags}, 32'b1000);
        exec(mk(4'hE, 4'h4, 1'b1, 4'h6), 32'h7FFF_FFFF, 1, 1);
        settle(); chk("R9 ADDS overflow flags", {28'h0, flags}, 32'b1001);
        exec(mk(4'hE, 4'h4, 1'b1, 4'h6), 32'hFFFF_FFFF, 1, 0);
        settle(); chk("R9 ADDS carry zero flags", {28'h0, flags}, 32'b0110);
        exec(mk(4'hE, 4'h2, 1'b1, 4'h6), 9, 4, 0);
        settle(); chk("R9 SUBS no borrow flags", {28'h0, flags}, 32'b0010);
    endtask

    task automatic t_logic_flags();
        set_flags(4'b0001);
        exec(mk(4'hE, 4'hD, 1'b1, 4'h7), 0, 32'h8000_0000, 0);
        settle(); chk("R10 MOVS keeps V", {28'h0, flags}, 32'b1001);
        exec(mk(4'hE, 4'h0, 1'b1, 4'h7), 32'h0F, 32'hF0, 1);
        settle(); chk("R10 ANDS zero", {28'h0, flags}, 32'b0111);
    endtask

    task automatic t_s_clear();
        set_flags(4'b0000);
        exec(mk(4'hE, 4'h4, 1'b0, 4'h8), 32'h7FFF_FFFF, 1, 0);
        chk("R8 ADD result", res, 32'h8000_0000);
        settle(); chk("R8 flags unchanged", {28'h0, flags}, 32'h0);
    endtask

    task automatic t_cond_fail();
        set_flags(4'b0000);
        exec(mk(4'h0, 4'h4, 1'b1, 4'h8), 0, 0, 1);
        chk("R11 failed cond no write", {31'h0, we}, 0);
        settle(); chk("R11 failed cond no flags", {28'h0, flags}, 32'h0);
    endtask

    task automatic t_class();
        set_flags(4'b0000);
        exec(mk(4'hE, 4'h4, 1'b1, 4'h8) | 32'h0400_0000, 0, 0, 1);
        chk("R12 class 01 no write", {31'h0, we}, 0);
        settle(); chk("R12 class 01 no flags", {28'h0, flags}, 32'h0);
    endtask

    task automatic t_dest();
        exec(mk(4'hE, 4'hD, 1'b1, 4'hA), 0, 32'h1234, 1);
        chk("R13 rd index", {28'h0, rd}, 32'hA);
        chk("R13 same-cycle result", res, 32'h1234);
        chk("R13 flags not yet updated", {28'h0, flags}, 32'h0);
        settle(); chk("R13 flags after edge", {28'h0, flags}, 32'b0010);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_cond_sweep();
        t_logical();
        t_arith();
        t_carry_ops();
        t_tests();
        t_arith_flags();
        t_logic_flags();
        t_s_clear();
        t_cond_fail();
        t_class();
        t_dest();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule